// File: doc/BRIEF.md
# PSRAM Power-Up Identification Sequencer

This block runs once after a synchronous reset, when it sees a start pulse. It brings a serial pseudo-static RAM out of an unknown bus state and leaves it in four-bit (QPI) operation. An internal command shifter drives four things: the chip select, a serial-clock enable and four data lines with per-line output enables. The shifter also samples returned data on line 1. Each asserted clock-enable cycle is one serial clock. The clock itself is generated outside the block.

The sequencer first sends a quad-width exit command so that a device left in quad mode returns to single-bit SPI. It then reads the 24-bit identifier. If the identifier fails its check, the sequencer reads it once more. From a good identifier it decodes the capacity, and it decides whether each later chip-select release must be followed by one extra clock. It finishes with a software reset pair and an enter-quad command, then raises done.

All status pins are plain levels. There is no streaming interface and no back-pressure. done and fail hold until the next reset.

Top module: `psram_boot_seq`

## Requirements
- R1: After reset, cs_n=1, sclk_en=0, dq_oe=0, done=0, fail=0, size_code=3 and extra_clk=0. No transaction begins until start is seen high.
- R2: The first transaction is opcode 0xF5 in quad width. It takes 2 clocks, all lines are enabled (dq_oe=4'hF), the high nibble goes first and each nibble's MSB is on dq_out[3]. There is no address or data phase.
- R3: An ID read is opcode 0x9F on dq_out[0], MSB first, with dq_oe=4'h1. It is followed by 24 zero address bits and then 24 bits sampled from dq_in[1], for 56 clocks in total. The first received byte is ID[7:0], then ID[15:8], then ID[23:16], each byte MSB first.
- R4: An identifier is valid only when ID[15:8] equals 0x5D.
- R5: An invalid first ID read is followed by exactly one more ID read. If the second read is also invalid, fail rises and stays high and no further transaction is sent.
- R6: size_code is decoded from ID[23:21]: 000 gives 0 (16 Mbit), 001 gives 1 (32 Mbit), 010 gives 2 (64 Mbit). Any other value gives 3 (unknown).
- R7: An ID[23:16] of exactly 0x26 gives size_code 2.
- R8: extra_clk is 1 only for ID[23:16]=0x20. In that case one sclk_en cycle with cs_n=1 follows the release of every later transaction. The exit and ID-read transactions always get that one extra clock, and parts with extra_clk=0 get none later.
- R9: After a valid ID, three SPI-width transactions follow in this order: 0x66, then 0x99, then 0x35, each lasting 8 clocks. done rises after the last one and stays high.
- R10: Each transaction has sclk_en high in its first cs_n-low cycle. Its last clock is followed by exactly one cycle with cs_n=0 and sclk_en=0. cs_n stays high for at least 2 cycles between transactions.
- R11: A start pulse during a running sequence, or after done or fail, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one serial bit per enabled cycle |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts the sequence once after reset |
| cs_n | output | 1 | Device chip select, active low |
| sclk_en | output | 1 | Serial clock enable for this cycle |
| dq_out | output | 4 | Data driven to the device |
| dq_oe | output | 4 | Per-line output enables |
| dq_in | input | 4 | Data from the device; line 1 is sampled in ID reads |
| done | output | 1 | Sequence finished with the device in quad mode |
| fail | output | 1 | Both ID reads were invalid |
| size_code | output | 2 | 0 = 16 Mbit, 1 = 32 Mbit, 2 = 64 Mbit, 3 = unknown |
| extra_clk | output | 1 | Device needs one clock after each chip-select release |

## Verification
The hardest situations to reach from the ports are the retry path and the double-failure stop. Reaching them needs a device that answers its two ID reads differently. The same applies to the extra-clock decision, which changes the gap timing of later commands only. The bench includes a device model that decodes each opcode from the lines. It counts clocks, hold cycles and released-select clocks per transaction, and it returns a per-read identifier taken from a table entry. This lets one table entry force an invalid first read followed by a valid or invalid second read.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_DATA, PH_HOLD, PH_GAP
  } shift_ph_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_EXIT, ST_ID1, ST_ID2, ST_RSTEN, ST_RST, ST_ENQ, ST_DONE, ST_FAIL
  } step_t;

  localparam logic [1:0] SZ_16  = 2'd0;
  localparam logic [1:0] SZ_32  = 2'd1;
  localparam logic [1:0] SZ_64  = 2'd2;
  localparam logic [1:0] SZ_UNK = 2'd3;

  localparam logic [7:0] OPC_EXITQ = 8'hF5;
  localparam logic [7:0] OPC_RDID  = 8'h9F;
  localparam logic [7:0] OPC_RSTEN = 8'h66;
  localparam logic [7:0] OPC_RST   = 8'h99;
  localparam logic [7:0] OPC_ENTQ  = 8'h35;

  typedef struct packed {
    logic [7:0] op;
    logic       quad;
    logic       addr;
    logic       rx;
    logic       xclk;
  } cmd_t;

endpackage

// File: rtl/psram_cmd_shifter.sv
module psram_cmd_shifter
  import psram_seq_pkg::*;
#(
  parameter int OP_W    = 8,
  parameter int ADDR_W  = 24,
  parameter int RX_W    = 24,
  parameter int GAP_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [OP_W-1:0] op,
  input  logic            quad,
  input  logic            with_addr,
  input  logic            with_rx,
  input  logic            xclk,
  input  logic [3:0]      dq_in,
  output logic            cs_n,
  output logic            sclk_en,
  output logic [3:0]      dq_out,
  output logic [3:0]      dq_oe,
  output logic [RX_W-1:0] rx_word,
  output logic            fin
);
  localparam int MAXAR = (ADDR_W > RX_W) ? ADDR_W : RX_W;
  localparam int MAXC  = (MAXAR > OP_W) ? MAXAR : OP_W;
  localparam int CW    = $clog2(MAXC + GAP_CYC + 1);

  shift_ph_t       ph;
  logic [CW-1:0]   cnt;
  logic [OP_W-1:0] tx;
  logic [RX_W-1:0] rx;
  logic            q_r, wa_r, wr_r, xc_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; cnt <= '0; tx <= '0; rx <= '0;
      q_r <= 1'b0; wa_r <= 1'b0; wr_r <= 1'b0; xc_r <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (go) begin
          ph <= PH_CMD; tx <= op;
          q_r <= quad; wa_r <= with_addr; wr_r <= with_rx; xc_r <= xclk;
          cnt <= quad ? CW'(OP_W/4 - 1) : CW'(OP_W - 1);
        end
        PH_CMD: begin
          if (cnt == '0) begin
            if (wa_r) begin
              ph <= PH_ADDR; cnt <= CW'(ADDR_W - 1);
            end else if (wr_r) begin
              ph <= PH_DATA; cnt <= CW'(RX_W - 1);
            end else begin
              ph <= PH_HOLD;
            end
          end else begin
            tx  <= q_r ? {tx[OP_W-5:0], 4'b0} : {tx[OP_W-2:0], 1'b0};
            cnt <= cnt - 1'b1;
          end
        end
        PH_ADDR: begin
          if (cnt == '0) begin
            if (wr_r) begin
              ph <= PH_DATA; cnt <= CW'(RX_W - 1);
            end else begin
              ph <= PH_HOLD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_DATA: begin
          rx <= {rx[RX_W-2:0], dq_in[1]};
          if (cnt == '0) ph <= PH_HOLD;
          else cnt <= cnt - 1'b1;
        end
        PH_HOLD: begin
          ph <= PH_GAP; cnt <= CW'(GAP_CYC - 1);
        end
        PH_GAP: begin
          if (cnt == '0) ph <= PH_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    cs_n    = (ph == PH_IDLE) || (ph == PH_GAP);
    sclk_en = (ph == PH_CMD) || (ph == PH_ADDR) || (ph == PH_DATA) ||
              ((ph == PH_GAP) && (cnt == CW'(GAP_CYC - 1)) && xc_r);
    dq_out  = 4'b0;
    dq_oe   = 4'b0;
    if (ph == PH_CMD) begin
      dq_out = q_r ? tx[OP_W-1 -: 4] : {3'b0, tx[OP_W-1]};
      dq_oe  = q_r ? 4'hF : 4'h1;
    end else if (ph == PH_ADDR) begin
      dq_oe  = 4'h1;
    end
    fin     = (ph == PH_GAP) && (cnt == '0);
    rx_word = rx;
  end

endmodule

// File: rtl/psram_id_decode.sv
module psram_id_decode
  import psram_seq_pkg::*;
#(
  parameter logic [7:0] GOOD_DIE = 8'h5D,
  parameter logic [7:0] TRIAL64  = 8'h26,
  parameter logic [7:0] EARLY32  = 8'h20
) (
  input  logic [15:0] raw_hi,
  output logic        valid,
  output logic [1:0]  size,
  output logic        early
);
  logic [7:0] kgd, ext;

  always_comb begin
    kgd   = raw_hi[15:8];
    ext   = raw_hi[7:0];
    valid = (kgd == GOOD_DIE);
    early = (ext == EARLY32);
    if ((ext[7:5] == 3'b010) || (ext == TRIAL64)) size = SZ_64;
    else if (ext[7:5] == 3'b001)                  size = SZ_32;
    else if (ext[7:5] == 3'b000)                  size = SZ_16;
    else                                          size = SZ_UNK;
  end

endmodule

// File: rtl/psram_boot_seq.sv
module psram_boot_seq
  import psram_seq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int ID_W    = 24,
  parameter int GAP_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       cs_n,
  output logic       sclk_en,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe,
  input  logic [3:0] dq_in,
  output logic       done,
  output logic       fail,
  output logic [1:0] size_code,
  output logic       extra_clk
);
  step_t           st;
  logic            launch;
  logic [1:0]      size_q;
  logic            early_q;
  cmd_t            cmd;
  logic            fin;
  logic [ID_W-1:0] rx_word;
  logic            id_ok, id_early;
  logic [1:0]      id_size;
  logic            unused_mfid;

  assign unused_mfid = ^rx_word[ID_W-1:16];

  always_comb begin
    cmd = '0;
    case (st)
      ST_EXIT:  cmd = '{op: OPC_EXITQ, quad: 1'b1, addr: 1'b0, rx: 1'b0, xclk: 1'b1};
      ST_ID1,
      ST_ID2:   cmd = '{op: OPC_RDID,  quad: 1'b0, addr: 1'b1, rx: 1'b1, xclk: 1'b1};
      ST_RSTEN: cmd = '{op: OPC_RSTEN, quad: 1'b0, addr: 1'b0, rx: 1'b0, xclk: early_q};
      ST_RST:   cmd = '{op: OPC_RST,   quad: 1'b0, addr: 1'b0, rx: 1'b0, xclk: early_q};
      ST_ENQ:   cmd = '{op: OPC_ENTQ,  quad: 1'b0, addr: 1'b0, rx: 1'b0, xclk: early_q};
      default:  cmd = '0;
    endcase
  end

  psram_cmd_shifter #(
    .OP_W(8), .ADDR_W(ADDR_W), .RX_W(ID_W), .GAP_CYC(GAP_CYC)
  ) shifter_i (
    .clk(clk), .rst(rst), .go(launch), .op(cmd.op), .quad(cmd.quad),
    .with_addr(cmd.addr), .with_rx(cmd.rx), .xclk(cmd.xclk), .dq_in(dq_in),
    .cs_n(cs_n), .sclk_en(sclk_en), .dq_out(dq_out), .dq_oe(dq_oe),
    .rx_word(rx_word), .fin(fin)
  );

  psram_id_decode decode_i (
    .raw_hi(rx_word[15:0]), .valid(id_ok), .size(id_size), .early(id_early)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; launch <= 1'b0; size_q <= SZ_UNK; early_q <= 1'b0;
    end else begin
      launch <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin st <= ST_EXIT; launch <= 1'b1; end
        ST_EXIT: if (fin)   begin st <= ST_ID1;  launch <= 1'b1; end
        ST_ID1, ST_ID2: if (fin) begin
          if (id_ok) begin
            st <= ST_RSTEN; launch <= 1'b1;
            size_q <= id_size; early_q <= id_early;
          end else if (st == ST_ID1) begin
            st <= ST_ID2; launch <= 1'b1;
          end else begin
            st <= ST_FAIL;
          end
        end
        ST_RSTEN: if (fin) begin st <= ST_RST; launch <= 1'b1; end
        ST_RST:   if (fin) begin st <= ST_ENQ; launch <= 1'b1; end
        ST_ENQ:   if (fin) st <= ST_DONE;
        default:  st <= st;
      endcase
    end
  end

  assign done      = (st == ST_DONE);
  assign fail      = (st == ST_FAIL);
  assign size_code = size_q;
  assign extra_clk = early_q;

endmodule

// File: rtl/psram_boot_seq_chk.sv
module psram_boot_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       sclk_en,
  input logic [3:0] dq_oe,
  input logic       done,
  input logic       fail
);
  // R10
  zero_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> sclk_en);

  // R10
  hold_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !$past(sclk_en));

  // R5
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fail |=> (fail && !done));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !fail));

  // R2
  quad_drive_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (dq_oe == 4'hF) |-> !cs_n);

  // R11
  quiet_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> (cs_n && (dq_oe == 4'h0)));

endmodule

bind psram_boot_seq psram_boot_seq_chk chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk_en(sclk_en),
  .dq_oe(dq_oe), .done(done), .fail(fail)
);

// File: tb/psram_boot_seq_tb_top.sv
`timescale 1ns/1ps
module psram_boot_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       cs_n, sclk_en, done, fail, extra_clk;
  logic [3:0] dq_out, dq_oe;
  logic [3:0] dq_in;
  logic [1:0] size_code;

  always #2.5 clk = ~clk;

  psram_boot_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .cs_n(cs_n), .sclk_en(sclk_en),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .done(done), .fail(fail),
    .size_code(size_code), .extra_clk(extra_clk)
  );

  int checks = 0;
  int errors = 0;

  // entry: {id_first, id_second, exp_fail, exp_size, exp_extra}
  localparam int NV = 10;
  localparam logic [51:0] VEC [NV] = '{
    {24'h405D0D, 24'h000000, 1'b0, 2'd2, 1'b0},
    {24'h205D0D, 24'h000000, 1'b0, 2'd1, 1'b1},
    {24'h005D0D, 24'h000000, 1'b0, 2'd0, 1'b0},
    {24'h265D0D, 24'h000000, 1'b0, 2'd2, 1'b0},
    {24'h225D0D, 24'h000000, 1'b0, 2'd1, 1'b0},
    {24'hE05D0D, 24'h000000, 1'b0, 2'd3, 1'b0},
    {24'h000000, 24'h205D0D, 1'b0, 2'd1, 1'b1},
    {24'h5C5C5C, 24'hFFFFFF, 1'b1, 2'd3, 1'b0},
    {24'h605D0D, 24'h000000, 1'b0, 2'd3, 1'b0},
    {24'h123456, 24'h405D0D, 1'b0, 2'd2, 1'b0}
  };

  // device model state
  logic [23:0] id_a, id_b;
  int          ntr;
  int          id_reads;
  logic [7:0]  op_log   [8];
  logic        quad_log [8];
  logic        setup_log[8];
  int          clk_log  [8];
  int          hold_log [8];
  int          xclk_log [8];
  int          gap_log  [8];

  initial begin
    int   ti;
    int   cur;
    logic prev_cs;
    logic [23:0] rid;
    dq_in = 4'b0; ntr = 0; id_reads = 0; prev_cs = 1'b1; ti = 0; cur = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        ntr = 0; id_reads = 0; prev_cs = 1'b1; dq_in = 4'b0; cur = 0;
      end else begin
        if (!cs_n) begin
          if (prev_cs) begin
            ntr++; ti = (ntr - 1) % 8; cur = 0;
            op_log[ti] = 8'h0; quad_log[ti] = (dq_oe == 4'hF);
            setup_log[ti] = sclk_en; clk_log[ti] = 0; hold_log[ti] = 0;
            xclk_log[ti] = 0; gap_log[ti] = 0;
          end
          if (sclk_en) begin
            if (quad_log[ti] && cur < 2)       op_log[ti] = {op_log[ti][3:0], dq_out};
            else if (!quad_log[ti] && cur < 8) op_log[ti] = {op_log[ti][6:0], dq_out[0]};
            dq_in = 4'b0;
            if (op_log[ti] == 8'h9F && cur >= 32 && cur < 56) begin
              rid = (id_reads == 0) ? id_a : id_b;
              dq_in[1] = rid[((cur - 32) / 8) * 8 + 7 - ((cur - 32) % 8)];
            end
            cur++; clk_log[ti] = cur;
          end else begin
            hold_log[ti]++;
          end
        end else begin
          dq_in = 4'b0;
          if (!prev_cs && op_log[ti] == 8'h9F) id_reads++;
          if (ntr > 0) begin
            gap_log[ti]++;
            if (sclk_en) xclk_log[ti]++;
          end
        end
        prev_cs = cs_n;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1; start = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic check_idle_state();
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk_en == 1'b0 && dq_oe == 4'h0, "R1 idle pins",
        {cs_n, sclk_en, dq_oe}, 6'b100000);
    chk(done == 1'b0 && fail == 1'b0, "R1 status", {done, fail}, 0);
    chk(size_code == 2'd3 && extra_clk == 1'b0, "R1 size/extra",
        {size_code, extra_clk}, 3'b110);
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || fail) && n < 3000) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
  endtask

  task automatic check_txn(input int i, input logic [7:0] eop, input bit eq,
                           input int eclk, input int ex, input bit last);
    chk(op_log[i] == eop, (eop == 8'hF5) ? "R2 opcode" :
        (eop == 8'h9F) ? "R3 opcode" : "R9 opcode", op_log[i], eop);
    chk(quad_log[i] == eq, eq ? "R2 quad width" : "R3 spi width", quad_log[i], eq);
    chk(clk_log[i] == eclk, "R3 clock count", clk_log[i], eclk);
    chk(setup_log[i] == 1'b1 && hold_log[i] == 1, "R10 setup/hold",
        {setup_log[i], hold_log[i][3:0]}, 5'b10001);
    chk(xclk_log[i] == ex, "R8 extra clock in gap", xclk_log[i], ex);
    if (!last) chk(gap_log[i] >= 2, "R10 gap", gap_log[i], 2);
  endtask

  initial begin
    logic [51:0] v;
    bit   retry, efail, eextra;
    logic [1:0] esize;
    int   k, n_exp;
    do_reset();
    check_idle_state();
    repeat (30) @(negedge clk);
    chk(ntr == 0 && cs_n == 1'b1, "R1 no start no traffic", ntr, 0);

    for (int vi = 0; vi < NV; vi++) begin
      v = VEC[vi];
      id_a = v[51:28]; id_b = v[27:4];
      efail = v[3]; esize = v[2:1]; eextra = v[0];
      retry = (id_a[15:8] != 8'h5D);
      do_reset();
      check_idle_state();
      pulse_start();
      wait_end();
      n_exp = 2 + (retry ? 1 : 0) + (efail ? 0 : 3);
      chk(ntr == n_exp, retry ? "R5 transaction count" : "R9 transaction count", ntr, n_exp);
      chk(done == !efail, "R9 done", done, !efail);
      chk(fail == efail, "R5 fail", fail, efail);
      chk(size_code == esize, (id_a[23:16] == 8'h26) ? "R7 size" : "R6 size", size_code, esize);
      chk(extra_clk == eextra, "R8 extra_clk", extra_clk, eextra);
      if (ntr == n_exp) begin
        check_txn(0, 8'hF5, 1'b1, 2, 1, 1'b0);
        check_txn(1, 8'h9F, 1'b0, 56, 1, efail && !retry);
        k = 2;
        if (retry) begin check_txn(2, 8'h9F, 1'b0, 56, 1, efail); k = 3; end
        if (!efail) begin
          check_txn(k,   8'h66, 1'b0, 8, eextra, 1'b0);
          check_txn(k+1, 8'h99, 1'b0, 8, eextra, 1'b0);
          check_txn(k+2, 8'h35, 1'b0, 8, eextra, 1'b1);
        end
      end
      // R4: validity hinges on byte [15:8] only
      chk((done || fail) && (retry == (id_a[15:8] != 8'h5D)), "R4 validity", {done, fail}, 2);
    end

    // R11: start after the end has no effect
    k = ntr;
    pulse_start();
    repeat (200) @(negedge clk);
    chk(ntr == k && cs_n == 1'b1, "R11 start after end", ntr, k);

    // R11: start pulse while running
    id_a = 24'h405D0D; id_b = 24'h0;
    do_reset();
    pulse_start();
    repeat (20) @(posedge clk);
    #1 start = 1'b1; @(posedge clk); #1 start = 1'b0;
    wait_end();
    chk(ntr == 5 && done == 1'b1, "R11 start while running", ntr, 5);

    // R1: reset mid-sequence returns pins to idle
    do_reset();
    pulse_start();
    repeat (40) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    check_idle_state();

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

endmodule